// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM with four internal banks out of power-up. Once a start pulse arrives it raises the clock-enable line and holds the bus quiet for a stabilization window, whose length in clocks is set by a parameter. It then issues one precharge of all banks and a fixed run of auto-refresh commands. After that it loads the mode register. Every gap between commands is counted in clocks against the device's minimum timings, and the bus carries NOP in each cycle between commands.

When the mode-register gap has run out, the block raises `init_done` and hands over to its periodic refresh timer. The timer is reloaded from the `refresh_count` input at the moment initialization completes. Each time it runs down it raises `refresh_req` and reloads itself. The request stays high until `refresh_ack` is seen.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and afterwards until a start pulse is seen, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (NOP), `addr` and `ba` are 0, and `init_done` and `refresh_req` are 0.
- R2: A start pulse sampled while idle raises `cke` in the next cycle, call it cycle 0. The bus then holds NOP through cycle WAIT_CYCLES-1. PRECHARGE ALL (command 0010, addr bit 10 = 1, all other addr bits 0) appears in cycle WAIT_CYCLES.
- R3: In every cycle that carries no sequence command, the command pins read 0111 (NOP) and `addr` and `ba` are 0.
- R4: Exactly NUM_REFRESH (default 4) AUTO REFRESH commands (0001) are issued. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R5: LOAD MODE REGISTER (0000) is issued T_RC cycles after the last refresh, with `ba`=00 and `addr`=0x231. The fields of 0x231 are: bits 2:0 = 001 (burst length 2), bit 3 = 0 (sequential), bits 6:4 = 011 (CAS latency 3), bits 8:7 = 00 (standard mode), bit 9 = 1 (single-location write burst), and bits 11:10 = 0.
- R6: `init_done` rises T_MRD+1 cycles after the cycle that carries LOAD MODE REGISTER, and stays high until reset.
- R7: A start pulse seen while the sequence is running, or after it has completed, has no effect on the bus. Only one precharge is issued per reset.
- R8: In the cycle where `init_done` rises, the refresh timer loads the value R on `refresh_count`. `refresh_req` is first set R+1 cycles after that, and then every R+1 cycles.
- R9: Once `refresh_req` is set, it stays high until `refresh_ack` is sampled high, and it falls in the cycle after that. If an acknowledge coincides with a new timer expiry, the request stays high.
- R10: Changes to `refresh_count` after `init_done` has risen do not affect the refresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the power-up sequence when the block is idle |
| refresh_count | input | 16 | Reload value R for the refresh timer, taken once at completion |
| refresh_ack | input | 1 | Acknowledges a pending refresh request |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | SDRAM address bus |
| ba | output | 2 | Bank select |
| init_done | output | 1 | High once initialization has finished |
| refresh_req | output | 1 | Periodic refresh request, held until acknowledged |

## Verification
The assertions check the following on every cycle:
- The bus carries NOP whenever clock enable is low, and every precharge and refresh is followed by a NOP.
- The mode-register load only appears after the full refresh count.
- `init_done` never falls.
- A pending refresh request is never dropped without an acknowledge, and each timer expiry reloads the period and raises the request.

Only the bench's scenarios can show the exact cycle positions of each command and of `init_done`, and the refresh period that follows from a given reload value. The same goes for ignoring starts in mid-sequence and ignoring reload changes made after completion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STAB,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_LMR,
    ST_WAIT_MRD,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4
  hold_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             enable,
  input  logic [REF_W-1:0] reload,
  input  logic             ack,
  output logic             req
);

  logic [REF_W-1:0] cnt;
  logic [REF_W-1:0] period;
  logic             hit;

  assign hit = enable && !arm && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      period <= '0;
    end else if (arm) begin
      cnt    <= reload;
      period <= reload;
    end else if (enable) begin
      if (cnt == '0) cnt <= period;
      else           cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      req <= 1'b0;
    else if (hit) req <= 1'b1;
    else if (ack) req <= 1'b0;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  // R8
  hit_reload_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (req && cnt == period));

  // R10
  period_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !arm) |=> $stable(period));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYCLES = 25000,
  parameter int T_RP        = 2,
  parameter int T_RC        = 7,
  parameter int T_MRD       = 2,
  parameter int NUM_REFRESH = 4,
  parameter int ROW_W       = 12,
  parameter int BANK_W      = 2,
  parameter int REF_W       = 16,
  parameter logic [2:0] BURST_CODE   = 3'b001,
  parameter logic [2:0] CAS_LAT      = 3'd3,
  parameter logic       WRITE_SINGLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [REF_W-1:0]  refresh_count,
  input  logic              refresh_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done,
  output logic              refresh_req
);

  localparam int MAX_GAP = (WAIT_CYCLES > T_RC) ? WAIT_CYCLES : T_RC;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int RCNT_W  = $clog2(NUM_REFRESH + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({WRITE_SINGLE, 2'b00, CAS_LAT, 1'b0, BURST_CODE});
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << 10;

  seq_state_t        state, nxt;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [RCNT_W-1:0] ref_cnt;
  logic              ref_arm;
  logic [3:0]        cmd;

  sdram_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_refresh_timer #(.REF_W(REF_W)) u_refresh (
    .clk    (clk),
    .rst    (rst),
    .arm    (ref_arm),
    .enable (state == ST_DONE),
    .reload (refresh_count),
    .ack    (refresh_ack),
    .req    (refresh_req)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_arm  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt      = ST_STAB;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WAIT_CYCLES - 1);
      end
      ST_STAB: if (tmr_expired) nxt = ST_PRE;
      ST_PRE: begin
        nxt      = ST_WAIT_RP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 2);
      end
      ST_WAIT_RP: if (tmr_expired) nxt = ST_REF;
      ST_REF: begin
        nxt      = ST_WAIT_RC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RC - 2);
      end
      ST_WAIT_RC: if (tmr_expired) begin
        nxt = (ref_cnt == RCNT_W'(NUM_REFRESH)) ? ST_LMR : ST_REF;
      end
      ST_LMR: begin
        nxt      = ST_WAIT_MRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_MRD - 1);
      end
      ST_WAIT_MRD: if (tmr_expired) begin
        nxt     = ST_DONE;
        ref_arm = 1'b1;
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ref_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE)     ref_cnt <= '0;
      else if (state == ST_REF) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    case (state)
      ST_PRE: begin cmd = CMD_PRE; addr = ALL_BANKS; end
      ST_REF: cmd = CMD_REF;
      ST_LMR: begin cmd = CMD_LMR; addr = MODE_WORD; end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba        = '0;
  assign cke       = (state != ST_IDLE);
  assign init_done = (state == ST_DONE);

  // R3
  nop_without_cke_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R4
  nop_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == CMD_PRE || {cs_n, ras_n, cas_n, we_n} == CMD_REF)
    |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R5
  lmr_after_all_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == CMD_LMR) |-> (ref_cnt == RCNT_W'(NUM_REFRESH)));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && start) |=> cke);

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int W     = 20;
  localparam int TRP   = 2;
  localparam int TRC   = 7;
  localparam int TMRD  = 2;
  localparam int NREF  = 4;
  localparam int PRE_T  = W;
  localparam int REF0_T = W + TRP;
  localparam int LMR_T  = W + TRP + NREF * TRC;
  localparam int DONE_T = LMR_T + TMRD + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] refresh_count = 16'd5;
  logic        refresh_ack = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [11:0] addr;
  logic [1:0]  ba;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int pre_seen = 0;
  string req_tag = "R8";

  // reference model state
  bit m_started;
  int m_t;
  int m_cnt, m_period;
  bit m_req;

  always #2 clk = ~clk;

  sdram_init_seq #(.WAIT_CYCLES(W), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
                   .NUM_REFRESH(NREF)) uut (
    .clk(clk), .rst(rst), .start(start), .refresh_count(refresh_count),
    .refresh_ack(refresh_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .init_done(init_done), .refresh_req(refresh_req));

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0d)", tag, what, act, exp, m_t);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_started = 0; m_t = 0; m_cnt = 0; m_period = 0; m_req = 0;
    end else begin
      if (!m_started) begin
        if (start) begin m_started = 1; m_t = 0; end
      end else m_t++;
      if (m_started && m_t == DONE_T) begin
        m_cnt = refresh_count; m_period = refresh_count;
      end else if (m_started && m_t > DONE_T) begin
        if (m_cnt == 0) begin m_cnt = m_period; m_req = 1; end
        else begin m_cnt--; if (refresh_ack) m_req = 0; end
      end
    end
  end

  always @(negedge clk) begin
    int e_cmd, e_addr, e_cke;
    string tag;
    e_cmd = 4'b0111; e_addr = 0; e_cke = m_started ? 1 : 0;
    tag = m_started ? "R3" : "R1";
    if (m_started) begin
      if (m_t < PRE_T) tag = "R2";
      if (m_t == PRE_T) begin e_cmd = 4'b0010; e_addr = 12'h400; tag = "R2"; end
      for (int k = 0; k < NREF; k++)
        if (m_t == REF0_T + k * TRC) begin e_cmd = 4'b0001; tag = "R4"; end
      if (m_t == LMR_T) begin e_cmd = 4'b0000; e_addr = 12'h231; tag = "R5"; end
    end
    if ({cs_n, ras_n, cas_n, we_n} == 4'b0010) pre_seen++;
    check(m_started ? "R2" : "R1", "cke", cke, e_cke);
    check(tag, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
    check(tag, "addr/ba", {ba, addr}, e_addr);
    check(m_started ? "R6" : "R1", "init_done", init_done,
          (m_started && m_t >= DONE_T) ? 1 : 0);
    check(m_started ? req_tag : "R1", "refresh_req", refresh_req, m_req);
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset and idle
    wait_neg(3);
    rst = 1'b0;
    wait_neg(6);
    // R2: start the sequence
    start = 1'b1; wait_neg(1); start = 1'b0;
    // R7: starts mid-sequence are ignored
    wait_neg(25); start = 1'b1; wait_neg(1); start = 1'b0;
    wait_neg(DONE_T - 20);
    start = 1'b1; wait_neg(1); start = 1'b0;
    // R9: request held without ack, then sparse acks
    req_tag = "R9";
    for (int i = 0; i < 60; i++) begin
      refresh_ack = (i % 9 == 8);
      wait_neg(1);
    end
    refresh_ack = 1'b0;
    check("R7", "precharge count", pre_seen, 1);
    // R10: reload changes after completion are ignored; ack held high
    req_tag = "R10";
    refresh_count = 16'd2;
    refresh_ack = 1'b1;
    wait_neg(30);
    refresh_ack = 1'b0;
    // second run with a different reload value
    rst = 1'b1; wait_neg(2); rst = 1'b0;
    check("R1", "refresh_req after reset", refresh_req, 0);
    req_tag = "R8";
    refresh_count = 16'd3;
    wait_neg(2);
    start = 1'b1; wait_neg(1); start = 1'b0;
    wait_neg(DONE_T + 2);
    for (int i = 0; i < 40; i++) begin
      refresh_ack = (i % 4 == 1);
      wait_neg(1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule